// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block is a purely combinational 32-bit shifter that produces the second operand of an integer datapath. It takes an operand, a two-bit shift kind, a shift count and the incoming carry flag. It returns the shifted value, the shifter carry-out, and negative and zero indications that the execute stage may use to update its flags.

The shift count comes from one of two sources. The first is a five-bit field taken from the instruction. The second is the low byte of a register. `use_reg_i` selects the source. The two sources follow different rules. Immediate zero is a special encoding: it means a shift of 32 for the right shifts, and a one-bit rotate through carry for the rotate. A register count is instead clamped for large values, and a register count of zero leaves both the operand and the carry untouched.

Top module: `shf_barrel`

## Requirements
- R1: The `kind_i` field is decoded as 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. For a count n from 1 to 31, the result is the operand shifted by n. The carry-out is the last bit shifted out: operand bit 32-n for a left shift, and operand bit n-1 for a right shift or rotate.
- R2: With the immediate source, a logical left by 0 returns the operand unchanged, and `carry_o` equals `carry_i`.
- R3: With the immediate source, a rotate with count 0 is a one-bit rotate through carry. The result is `{carry_i, operand[31:1]}` and `carry_o` is `operand[0]`.
- R4: With the immediate source, a logical right or arithmetic right with count 0 acts as a shift of 32, and `carry_o` is `operand[31]`. The logical right gives 0. The arithmetic right gives 32 copies of `operand[31]`.
- R5: With the register source, a logical left or logical right by exactly 32 gives 0. The carry-out is `operand[0]` for the left shift and `operand[31]` for the right shift. Any count from 33 to 255 gives 0 with carry-out 0.
- R6: With the register source, a count of 0 returns the operand unchanged and `carry_o` equals `carry_i`, for every shift kind.
- R7: With the register source, an arithmetic right by 32 or more fills every result bit with `operand[31]`, and `carry_o` equals `operand[31]`.
- R8: With the register source, a rotate whose nonzero count has its low five bits equal to 0 returns the operand with `carry_o = operand[31]`. Any other nonzero count rotates right by its low five bits, with `carry_o` equal to result bit 31.
- R9: An arithmetic right shift copies `operand[31]` into every vacated top bit.
- R10: `neg_o` equals result bit 31, and `zero_o` is 1 exactly when the result is all zeros.
- R11: `use_reg_i` = 0 selects `amt_imm_i` and `use_reg_i` = 1 selects `amt_reg_i`. The count that is not selected has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to shift |
| kind_i | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| amt_imm_i | input | 5 | Count from the instruction field |
| amt_reg_i | input | 8 | Low byte of the count register |
| use_reg_i | input | 1 | 1 selects the register count |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Shifter carry-out |
| neg_o | output | 1 | Result bit 31 |
| zero_o | output | 1 | Result is zero |

## Verification
The block holds no state, so a wrong internal value shows up at the ports in the same evaluation as the inputs that caused it. A mistake in decoding the effective count is the likely fault. Such a mistake appears only at particular counts: immediate 0, register 0, 32, 33, multiples of 32, and large register values. The result or carry is then wrong only for those counts, so the directed tasks sweep every one of them for each shift kind and source. A broad random sweep against an independent bit-serial model follows.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shf_amt_dec.sv
module shf_amt_dec
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int IW   = $clog2(W),
  localparam int CW   = $clog2(W) + 2
) (
  input  shift_kind_e      kind_i,
  input  logic             use_reg_i,
  input  logic [IW-1:0]    imm_i,
  input  logic [AMT_W-1:0] reg_i,
  output logic [CW-1:0]    cnt_o,
  output logic             rrx_o
);
  localparam logic [AMT_W-1:0] LIM_LOG = AMT_W'(W + 1);
  localparam logic [AMT_W-1:0] LIM_ARI = AMT_W'(W);

  always_comb begin
    cnt_o = '0;
    rrx_o = 1'b0;
    if (!use_reg_i) begin
      unique case (kind_i)
        SK_LSL:         cnt_o = CW'(imm_i);
        SK_LSR, SK_ASR: cnt_o = (imm_i == '0) ? CW'(W) : CW'(imm_i);
        SK_ROR: begin
          if (imm_i == '0) rrx_o = 1'b1;
          else             cnt_o = CW'(imm_i);
        end
        default: cnt_o = '0;
      endcase
    end else begin
      unique case (kind_i)
        SK_LSL, SK_LSR: cnt_o = (reg_i > LIM_LOG) ? CW'(W + 1) : CW'(reg_i);
        SK_ASR:         cnt_o = (reg_i > LIM_ARI) ? CW'(W) : CW'(reg_i);
        SK_ROR: begin
          if (reg_i == '0)               cnt_o = '0;
          else if (reg_i[IW-1:0] == '0)  cnt_o = CW'(W);
          else                           cnt_o = CW'(reg_i[IW-1:0]);
        end
        default: cnt_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int W   = 32,
  localparam int IW = $clog2(W),
  localparam int CW = $clog2(W) + 2
) (
  input  logic [W-1:0]  op_i,
  input  shift_kind_e   kind_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          rrx_i,
  input  logic          carry_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o
);
  // one guard bit on the exit side holds the last bit shifted out
  logic [W:0]        lsl_w;
  logic [W:0]        lsr_w;
  logic signed [W:0] asr_w;
  logic [IW-1:0]     rot_s;
  logic [CW-1:0]     rot_back;
  logic [W-1:0]      ror_w;

  assign lsl_w    = {1'b0, op_i} << cnt_i;
  assign lsr_w    = {op_i, 1'b0} >> cnt_i;
  assign asr_w    = $signed({op_i, 1'b0}) >>> cnt_i;
  assign rot_s    = cnt_i[IW-1:0];
  assign rot_back = CW'(W) - CW'(rot_s);
  assign ror_w    = (op_i >> rot_s) | (op_i << rot_back);

  always_comb begin
    res_o   = op_i;
    carry_o = carry_i;
    if (rrx_i) begin
      res_o   = {carry_i, op_i[W-1:1]};
      carry_o = op_i[0];
    end else if (cnt_i != '0) begin
      unique case (kind_i)
        SK_LSL: begin res_o = lsl_w[W-1:0]; carry_o = lsl_w[W]; end
        SK_LSR: begin res_o = lsr_w[W:1];   carry_o = lsr_w[0]; end
        SK_ASR: begin res_o = asr_w[W:1];   carry_o = asr_w[0]; end
        SK_ROR: begin res_o = ror_w;        carry_o = ror_w[W-1]; end
        default: begin res_o = op_i; carry_o = carry_i; end
      endcase
    end
  end
endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  output logic         neg_o,
  output logic         zero_o
);
  assign neg_o  = res_i[W-1];
  assign zero_o = (res_i == '0);
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int IW   = $clog2(W),
  localparam int CW   = $clog2(W) + 2
) (
  input  logic [W-1:0]     operand_i,
  input  logic [1:0]       kind_i,
  input  logic [IW-1:0]    amt_imm_i,
  input  logic [AMT_W-1:0] amt_reg_i,
  input  logic             use_reg_i,
  input  logic             carry_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o,
  output logic             neg_o,
  output logic             zero_o
);
  shift_kind_e   kind;
  logic [CW-1:0] cnt;
  logic          rrx;

  assign kind = shift_kind_e'(kind_i);

  shf_amt_dec #(.W(W), .AMT_W(AMT_W)) u_dec (
    .kind_i    (kind),
    .use_reg_i (use_reg_i),
    .imm_i     (amt_imm_i),
    .reg_i     (amt_reg_i),
    .cnt_o     (cnt),
    .rrx_o     (rrx)
  );

  shf_core #(.W(W)) u_core (
    .op_i    (operand_i),
    .kind_i  (kind),
    .cnt_i   (cnt),
    .rrx_i   (rrx),
    .carry_i (carry_i),
    .res_o   (result_o),
    .carry_o (carry_o)
  );

  shf_flags #(.W(W)) u_flags (
    .res_i  (result_o),
    .neg_o  (neg_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/shf_barrel_chk.sv
module shf_barrel_chk #(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int IW   = $clog2(W)
) (
  input logic [W-1:0]     operand_i,
  input logic [1:0]       kind_i,
  input logic [IW-1:0]    amt_imm_i,
  input logic [AMT_W-1:0] amt_reg_i,
  input logic             use_reg_i,
  input logic             carry_i,
  input logic [W-1:0]     result_o,
  input logic             carry_o,
  input logic             neg_o,
  input logic             zero_o
);
  always_comb begin
    if (!use_reg_i && kind_i == 2'b11 && amt_imm_i == '0)
      AST_RRX_CARRY_IN: assert (result_o[W-1] == carry_i && carry_o == operand_i[0]); // R3
    if (use_reg_i && amt_reg_i == '0)
      AST_REG_ZERO_KEEP: assert (result_o == operand_i && carry_o == carry_i); // R6
    if (use_reg_i && kind_i == 2'b00 && amt_reg_i > AMT_W'(W))
      AST_LSL_OVER_ZERO: assert (result_o == '0 && carry_o == 1'b0); // R5
    if (use_reg_i && kind_i == 2'b10 && amt_reg_i >= AMT_W'(W))
      AST_ASR_SIGN_FILL: assert (result_o == {W{operand_i[W-1]}} && carry_o == operand_i[W-1]); // R7
    if (!use_reg_i && kind_i == 2'b00 && amt_imm_i == '0)
      AST_IMM_LSL_PASS: assert (result_o == operand_i && carry_o == carry_i); // R2
    AST_FLAGS_AGREE: assert (!(zero_o && neg_o)); // R10
  end
endmodule

bind shf_barrel shf_barrel_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
  .operand_i (operand_i),
  .kind_i    (kind_i),
  .amt_imm_i (amt_imm_i),
  .amt_reg_i (amt_reg_i),
  .use_reg_i (use_reg_i),
  .carry_i   (carry_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .neg_o     (neg_o),
  .zero_o    (zero_o)
);

// File: tb/sim_shf_barrel.sv
`timescale 1ns/1ps
module sim_shf_barrel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] operand;
  logic [1:0]  kind;
  logic [4:0]  amt_imm;
  logic [7:0]  amt_reg;
  logic        use_reg;
  logic        cin;
  logic [31:0] result;
  logic        cout, neg, zero;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shf_barrel u0 (
    .operand_i (operand), .kind_i (kind), .amt_imm_i (amt_imm),
    .amt_reg_i (amt_reg), .use_reg_i (use_reg), .carry_i (cin),
    .result_o (result), .carry_o (cout), .neg_o (neg), .zero_o (zero)
  );

  // bit-serial reference
  function automatic void model(input logic [31:0] op, input logic [1:0] k,
      input logic ur, input logic [4:0] im, input logic [7:0] ra, input logic ci,
      output logic [31:0] r, output logic co);
    int n = 0;
    bit ext = 0;
    r = op; co = ci;
    if (!ur) begin
      case (k)
        2'd0: n = im;
        2'd1, 2'd2: n = (im == 0) ? 32 : im;
        default: if (im == 0) ext = 1; else n = im;
      endcase
    end else begin
      case (k)
        2'd0, 2'd1: n = (ra > 33) ? 33 : ra;
        2'd2: n = (ra > 32) ? 32 : ra;
        default: n = (ra == 0) ? 0 : ((ra[4:0] == 0) ? 32 : ra[4:0]);
      endcase
    end
    if (ext) begin
      co = op[0]; r = {ci, op[31:1]};
      return;
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin co = r[31]; r = r << 1; end
        2'd1: begin co = r[0]; r = r >> 1; end
        2'd2: begin co = r[0]; r = {r[31], r[31:1]}; end
        default: begin co = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endfunction

  task automatic apply(input logic [31:0] op, input logic [1:0] k, input logic ur,
                       input logic [4:0] im, input logic [7:0] ra, input logic ci);
    @(posedge clk);
    operand = op; kind = k; use_reg = ur; amt_imm = im; amt_reg = ra; cin = ci;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [31:0] er, input logic ec);
    n_run++;
    if (result !== er || cout !== ec) begin
      n_fail++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b", req, result, cout, er, ec);
    end
  endtask

  task automatic expect_model(input string req);
    logic [31:0] er;
    logic ec;
    model(operand, kind, use_reg, amt_imm, amt_reg, cin, er, ec);
    expect_out(req, er, ec);
  endtask

  task automatic expect_flags(input string req);
    n_run++;
    if (neg !== result[31] || zero !== (result == 32'h0)) begin
      n_fail++;
      $display("FAIL %s: neg=%b zero=%b expected neg=%b zero=%b", req, neg, zero,
               result[31], (result == 32'h0));
    end
  endtask

  task automatic t_reset;
    apply(32'h0, 2'd0, 1'b0, 5'd0, 8'd0, 1'b0);
    expect_out("R2 reset idle", 32'h0, 1'b0);
    n_run++;
    if (zero !== 1'b1 || neg !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset flags: neg=%b zero=%b expected neg=0 zero=1", neg, zero);
    end
  endtask

  task automatic t_imm_basic;
    apply(32'h8000_0001, 2'd0, 1'b0, 5'd1, 8'd0, 1'b0);
    expect_out("R1 lsl1", 32'h0000_0002, 1'b1);
    apply(32'h0000_0003, 2'd1, 1'b0, 5'd1, 8'd0, 1'b0);
    expect_out("R1 lsr1", 32'h0000_0001, 1'b1);
    apply(32'h1234_5678, 2'd3, 1'b0, 5'd4, 8'd0, 1'b0);
    expect_out("R1 ror4", 32'h8123_4567, 1'b1);
    for (int k = 0; k < 4; k++)
      for (int a = 1; a < 32; a++) begin
        apply(32'hA5C3_0F96, 2'(k), 1'b0, 5'(a), 8'hFF, 1'b1);
        expect_model("R1 imm sweep");
      end
  endtask

  task automatic t_imm_zero;
    apply(32'hDEAD_BEEF, 2'd0, 1'b0, 5'd0, 8'd7, 1'b1);
    expect_out("R2 imm lsl0 c1", 32'hDEAD_BEEF, 1'b1);
    apply(32'hDEAD_BEEF, 2'd0, 1'b0, 5'd0, 8'd7, 1'b0);
    expect_out("R2 imm lsl0 c0", 32'hDEAD_BEEF, 1'b0);
    apply(32'h0000_0003, 2'd3, 1'b0, 5'd0, 8'd0, 1'b1);
    expect_out("R3 rrx c1", 32'h8000_0001, 1'b1);
    apply(32'h8000_0002, 2'd3, 1'b0, 5'd0, 8'd0, 1'b0);
    expect_out("R3 rrx c0", 32'h4000_0001, 1'b0);
    apply(32'h8000_0000, 2'd1, 1'b0, 5'd0, 8'd0, 1'b0);
    expect_out("R4 lsr imm0", 32'h0, 1'b1);
    apply(32'h8000_0000, 2'd2, 1'b0, 5'd0, 8'd0, 1'b0);
    expect_out("R4 asr imm0 neg", 32'hFFFF_FFFF, 1'b1);
    apply(32'h7FFF_FFFF, 2'd2, 1'b0, 5'd0, 8'd0, 1'b1);
    expect_out("R4 asr imm0 pos", 32'h0, 1'b0);
  endtask

  task automatic t_reg_clamp;
    apply(32'h0000_0001, 2'd0, 1'b1, 5'd3, 8'd32, 1'b0);
    expect_out("R5 lsl32", 32'h0, 1'b1);
    apply(32'h8000_0000, 2'd1, 1'b1, 5'd3, 8'd32, 1'b0);
    expect_out("R5 lsr32", 32'h0, 1'b1);
    apply(32'hFFFF_FFFF, 2'd0, 1'b1, 5'd3, 8'd33, 1'b1);
    expect_out("R5 lsl33", 32'h0, 1'b0);
    apply(32'hFFFF_FFFF, 2'd1, 1'b1, 5'd3, 8'd200, 1'b1);
    expect_out("R5 lsr200", 32'h0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      apply(32'h9ABC_DEF1, 2'(k), 1'b1, 5'd9, 8'd0, 1'b1);
      expect_out("R6 reg0 keep c1", 32'h9ABC_DEF1, 1'b1);
      apply(32'h9ABC_DEF1, 2'(k), 1'b1, 5'd9, 8'd0, 1'b0);
      expect_out("R6 reg0 keep c0", 32'h9ABC_DEF1, 1'b0);
    end
    apply(32'h8000_0000, 2'd2, 1'b1, 5'd0, 8'd32, 1'b0);
    expect_out("R7 asr32 neg", 32'hFFFF_FFFF, 1'b1);
    apply(32'h4000_0000, 2'd2, 1'b1, 5'd0, 8'd255, 1'b1);
    expect_out("R7 asr255 pos", 32'h0, 1'b0);
    for (int a = 30; a < 40; a++)
      for (int k = 0; k < 3; k++) begin
        apply(32'hC000_0001, 2'(k), 1'b1, 5'd0, 8'(a), 1'b0);
        expect_model("R5 R7 border sweep");
      end
  endtask

  task automatic t_reg_ror;
    apply(32'h8000_0001, 2'd3, 1'b1, 5'd0, 8'd32, 1'b0);
    expect_out("R8 ror32", 32'h8000_0001, 1'b1);
    apply(32'h0000_0001, 2'd3, 1'b1, 5'd0, 8'd64, 1'b1);
    expect_out("R8 ror64", 32'h0000_0001, 1'b0);
    apply(32'h0000_0010, 2'd3, 1'b1, 5'd0, 8'd37, 1'b0);
    expect_out("R8 ror37", 32'h8000_0000, 1'b1);
    apply(32'h0000_00F0, 2'd3, 1'b1, 5'd0, 8'd4, 1'b1);
    expect_out("R8 ror4", 32'h0000_000F, 1'b0);
  endtask

  task automatic t_asr;
    apply(32'h8000_0000, 2'd2, 1'b0, 5'd4, 8'd0, 1'b0);
    expect_out("R9 asr4 neg", 32'hF800_0000, 1'b0);
    apply(32'h8000_0010, 2'd2, 1'b1, 5'd0, 8'd5, 1'b0);
    expect_out("R9 asr5 reg", 32'hFC00_0000, 1'b1);
  endtask

  task automatic t_flags;
    apply(32'h4000_0000, 2'd0, 1'b0, 5'd1, 8'd0, 1'b0);
    expect_flags("R10 neg set");
    n_run++;
    if (neg !== 1'b1 || zero !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 neg: neg=%b zero=%b expected neg=1 zero=0", neg, zero);
    end
    apply(32'h0000_0001, 2'd1, 1'b0, 5'd1, 8'd0, 1'b0);
    n_run++;
    if (zero !== 1'b1 || neg !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 zero: neg=%b zero=%b expected neg=0 zero=1", neg, zero);
    end
  endtask

  task automatic t_select_ignored;
    for (int v = 0; v < 256; v += 37) begin
      apply(32'h0000_0100, 2'd1, 1'b0, 5'd4, 8'(v), 1'b0);
      expect_out("R11 reg count ignored", 32'h0000_0010, 1'b0);
    end
    for (int v = 0; v < 32; v += 5) begin
      apply(32'h0000_0100, 2'd1, 1'b1, 5'(v), 8'd8, 1'b1);
      expect_out("R11 imm count ignored", 32'h0000_0001, 1'b0);
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 3000; i++) begin
      apply($urandom, 2'($urandom), 1'($urandom), 5'($urandom), 8'($urandom), 1'($urandom));
      expect_model("R1 R9 random");
      if (i % 10 == 0) expect_flags("R10 random");
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    operand = '0; kind = '0; amt_imm = '0; amt_reg = '0; use_reg = 1'b0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset;
    t_imm_basic;
    t_imm_zero;
    t_reg_clamp;
    t_reg_ror;
    t_asr;
    t_flags;
    t_select_ignored;
    t_random;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule